// File: doc/BRIEF.md
# Segmented Comparand and Mask Register File

This block holds one 64-bit comparand and seven 64-bit mask registers. A host reaches them through a 32-bit port, one half at a time. A segment-select input chooses which half a command touches. Commands arrive as a control code on a 12-bit control bus. A command is taken only when the command-enable input is high and the active-low address-valid input is high. An active-low write line sets the direction.

Reads return the chosen half through a registered data-out port. An output-enable flag is high for exactly one cycle to mark that data. The full 64-bit contents of the mask chosen by a separate select input are exported combinationally. The masked-write logic of a neighbouring memory port uses that value. Mask slot 0 stands for "no mask". Writes to slot 0 are dropped, so it always exports zero.

Top module: `segmask_regfile`

## Requirements
- R1: After reset, all registers are zero, `dout` is zero, `dout_oe` is low and `mask_word` is zero for every `mask_sel`.
- R2: A write with `seg_hi`=0 loads `din` into bits 31–0 of the addressed register and leaves bits 63–32 unchanged.
- R3: A write with `seg_hi`=1 loads `din` into bits 63–32 of the addressed register and leaves bits 31–0 unchanged.
- R4: A mask command has `ctl[5:0]`=6'b001001, with the mask index in `ctl[8:6]`. The bits `ctl[11:9]` have no effect.
- R5: A write to mask index 0 changes no register, so `mask_word` stays zero with `mask_sel`=0.
- R6: A comparand command has `ctl[5:0]`=6'b000101. `wr_n` low writes the chosen half and `wr_n` high reads it.
- R7: A read command taken at a clock edge puts the chosen half on `dout`, with `dout_oe` high, for exactly the following cycle.
- R8: No register changes when `cmd_en` is low, when `av_n` is low, or when `ctl[5:0]` matches neither opcode.
- R9: `mask_word` equals all 64 bits of mask register `mask_sel`, with no clock delay. Index 0 gives zero.
- R10: A write command never raises `dout_oe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_en | input | 1 | Command present this cycle |
| av_n | input | 1 | Active-low address valid; high means `ctl` holds a control code |
| wr_n | input | 1 | Active-low write; high means read |
| seg_hi | input | 1 | 0 selects bits 31–0, 1 selects bits 63–32 |
| ctl | input | 12 | Control code |
| din | input | 32 | Write data half |
| dout | output | 32 | Registered read data half |
| dout_oe | output | 1 | High for the cycle in which `dout` carries read data |
| mask_sel | input | 3 | Mask index for the export |
| mask_word | output | 64 | Full contents of mask `mask_sel` |

## Verification
The bench builds the block with its default parameters: 32-bit halves, a 12-bit control code and a 3-bit mask index. With these values every slot, including the reserved slot 0, is reachable in a few cycles. The don't-care code bits 11–9 also exist, so their having no effect can be shown. With both halves the same width, separate patterns in each half expose a write that strays into the wrong segment.

// File: rtl/segmask_regfile.sv
module segmask_regfile #(
  parameter int HALF_W = 32,
  parameter int CTL_W  = 12,
  parameter int IDX_W  = 3,
  parameter logic [5:0] OPC_MASK = 6'b001001,
  parameter logic [5:0] OPC_COMP = 6'b000101
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_en,
  input  logic                av_n,
  input  logic                wr_n,
  input  logic                seg_hi,
  input  logic [CTL_W-1:0]    ctl,
  input  logic [HALF_W-1:0]   din,
  output logic [HALF_W-1:0]   dout,
  output logic                dout_oe,
  input  logic [IDX_W-1:0]    mask_sel,
  output logic [2*HALF_W-1:0] mask_word
);
  localparam int FULL_W = 2 * HALF_W;
  localparam int NREG   = 1 << IDX_W;
  localparam int IDX_LO = 6;

  logic [NREG-1:0][FULL_W-1:0] mregs;
  logic [FULL_W-1:0]           comp;

  wire access   = cmd_en & av_n;
  wire hit_mask = access && (ctl[5:0] == OPC_MASK);
  wire hit_comp = access && (ctl[5:0] == OPC_COMP);
  wire [IDX_W-1:0] idx = ctl[IDX_LO+IDX_W-1:IDX_LO];

  logic unused_ctl;
  assign unused_ctl = &{1'b0, ctl[CTL_W-1:IDX_LO+IDX_W]};

  assign mask_word = mregs[mask_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mregs   <= '0;
      comp    <= '0;
      dout    <= '0;
      dout_oe <= 1'b0;
    end else begin
      dout_oe <= 1'b0;
      if (hit_mask) begin
        if (!wr_n) begin
          if (idx != '0) begin
            if (seg_hi) mregs[idx][FULL_W-1:HALF_W] <= din;
            else        mregs[idx][HALF_W-1:0]      <= din;
          end
        end else begin
          dout    <= seg_hi ? mregs[idx][FULL_W-1:HALF_W] : mregs[idx][HALF_W-1:0];
          dout_oe <= 1'b1;
        end
      end else if (hit_comp) begin
        if (!wr_n) begin
          if (seg_hi) comp[FULL_W-1:HALF_W] <= din;
          else        comp[HALF_W-1:0]      <= din;
        end else begin
          dout    <= seg_hi ? comp[FULL_W-1:HALF_W] : comp[HALF_W-1:0];
          dout_oe <= 1'b1;
        end
      end
    end
  end

  wire wr_cmd = access && !wr_n;

  AST_LOW_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !seg_hi) |=> ($stable(comp[FULL_W-1:HALF_W]) && $stable(mregs[NREG-1][FULL_W-1:HALF_W]))); // R2
  AST_HIGH_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && seg_hi) |=> ($stable(comp[HALF_W-1:0]) && $stable(mregs[NREG-1][HALF_W-1:0]))); // R3
  AST_RSVD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    mregs[0] == '0); // R5
  AST_OE_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> $past(access && wr_n)); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cmd |=> ($stable(mregs) && $stable(comp))); // R8
  AST_SEL0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_sel == '0) |-> (mask_word == '0)); // R9
  AST_WRITE_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> !dout_oe); // R10
endmodule

// File: tb/segmask_regfile_test.sv
`timescale 1ns/1ps
module segmask_regfile_test;
  logic clk = 0, rst_n = 0, cmd_en = 0, av_n = 1, wr_n = 1, seg_hi = 0;
  logic [11:0] ctl = '0;
  logic [31:0] din = '0, dout;
  logic dout_oe;
  logic [2:0] mask_sel = '0;
  logic [63:0] mask_word;
  int checks = 0, errors = 0;
  logic [63:0] mm [8];
  logic [63:0] cm;

  always #4 clk = ~clk;

  segmask_regfile uut (.clk, .rst_n, .cmd_en, .av_n, .wr_n, .seg_hi, .ctl,
                       .din, .dout, .dout_oe, .mask_sel, .mask_word);

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [11:0] mcode(input logic [2:0] top, input logic [2:0] idx);
    return {top, idx, 6'b001001};
  endfunction
  localparam logic [11:0] CCODE = 12'h005;

  task automatic wr(input logic av, input logic seg, input logic [11:0] c, input logic [31:0] d);
    @(negedge clk);
    cmd_en = 1; av_n = av; wr_n = 0; seg_hi = seg; ctl = c; din = d;
    @(negedge clk);
    check("R10 no oe on write", {63'd0, dout_oe}, 64'd0);
    cmd_en = 0; wr_n = 1;
  endtask

  task automatic rd(input logic seg, input logic [11:0] c, output logic [31:0] q);
    @(negedge clk);
    cmd_en = 1; av_n = 1; wr_n = 1; seg_hi = seg; ctl = c;
    @(negedge clk);
    check("R7 oe high after read", {63'd0, dout_oe}, 64'd1);
    q = dout;
    cmd_en = 0;
    @(negedge clk);
    check("R7 oe one cycle", {63'd0, dout_oe}, 64'd0);
  endtask

  task automatic export_check(input string tag, input logic [2:0] i, input logic [63:0] exp);
    @(negedge clk);
    mask_sel = i;
    #1 check(tag, mask_word, exp);
  endtask

  task automatic t_reset;
    check("R1 dout", {32'd0, dout}, 64'd0);
    check("R1 oe", {63'd0, dout_oe}, 64'd0);
    for (int i = 0; i < 8; i++) export_check("R1 mask zero", 3'(i), 64'd0);
  endtask

  task automatic t_halves;
    logic [31:0] q;
    for (int i = 1; i < 8; i++) begin
      wr(1, 0, mcode(3'd0, 3'(i)), 32'h1000_0000 + i);
      mm[i][31:0] = 32'h1000_0000 + i;
    end
    export_check("R2 low half only", 3'd3, mm[3]);
    wr(1, 1, mcode(3'd0, 3'd3), 32'hABCD_0003);
    mm[3][63:32] = 32'hABCD_0003;
    export_check("R3 high half only", 3'd3, mm[3]);
    wr(1, 0, mcode(3'd0, 3'd3), 32'h5555_AAAA);
    mm[3][31:0] = 32'h5555_AAAA;
    export_check("R2 high kept", 3'd3, mm[3]);
    rd(1, mcode(3'd0, 3'd3), q); check("R3 read high", {32'd0, q}, {32'd0, mm[3][63:32]});
    rd(0, mcode(3'd0, 3'd3), q); check("R2 read low", {32'd0, q}, {32'd0, mm[3][31:0]});
    for (int i = 1; i < 8; i++) export_check("R9 export", 3'(i), mm[i]);
  endtask

  task automatic t_dontcare;
    logic [31:0] q;
    wr(1, 1, mcode(3'd7, 3'd5), 32'hDEAD_BEEF);
    mm[5][63:32] = 32'hDEAD_BEEF;
    export_check("R4 top bits ignored on write", 3'd5, mm[5]);
    rd(1, mcode(3'd5, 3'd5), q); check("R4 top bits ignored on read", {32'd0, q}, {32'd0, mm[5][63:32]});
  endtask

  task automatic t_reserved;
    logic [31:0] q;
    wr(1, 0, mcode(3'd0, 3'd0), 32'hFFFF_FFFF);
    wr(1, 1, mcode(3'd0, 3'd0), 32'hFFFF_FFFF);
    export_check("R5 slot0 empty", 3'd0, 64'd0);
    for (int i = 1; i < 8; i++) export_check("R5 others kept", 3'(i), mm[i]);
    rd(0, mcode(3'd0, 3'd0), q);
  endtask

  task automatic t_comp;
    logic [31:0] q;
    wr(1, 0, CCODE, 32'h0123_4567); cm[31:0] = 32'h0123_4567;
    wr(1, 1, CCODE, 32'h89AB_CDEF); cm[63:32] = 32'h89AB_CDEF;
    rd(0, CCODE, q); check("R6 comp low", {32'd0, q}, {32'd0, cm[31:0]});
    rd(1, CCODE, q); check("R6 comp high", {32'd0, q}, {32'd0, cm[63:32]});
    for (int i = 1; i < 8; i++) export_check("R6 masks untouched", 3'(i), mm[i]);
  endtask

  task automatic t_ignored;
    logic [31:0] q;
    wr(0, 0, mcode(3'd0, 3'd2), 32'h7777_7777);
    export_check("R8 av_n low ignored", 3'd2, mm[2]);
    wr(1, 0, 12'h03F, 32'h6666_6666);
    for (int i = 1; i < 8; i++) export_check("R8 bad opcode ignored", 3'(i), mm[i]);
    @(negedge clk);
    cmd_en = 0; av_n = 1; wr_n = 0; seg_hi = 0; ctl = mcode(3'd0, 3'd2); din = 32'h4444_4444;
    @(negedge clk);
    wr_n = 1;
    export_check("R8 cmd_en low ignored", 3'd2, mm[2]);
    rd(0, CCODE, q); check("R8 comp kept", {32'd0, q}, {32'd0, cm[31:0]});
    @(negedge clk);
    cmd_en = 1; av_n = 0; wr_n = 1; ctl = CCODE;
    @(negedge clk);
    check("R8 no read with av_n low", {63'd0, dout_oe}, 64'd0);
    cmd_en = 0; av_n = 1;
  endtask

  initial begin
    for (int i = 0; i < 8; i++) mm[i] = '0;
    cm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_halves();
    t_dontcare();
    t_reserved();
    t_comp();
    t_ignored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule